// File: doc/BRIEF.md
# Burst Column Address Generator

This block works out the column addresses of one synchronous DRAM read or write burst. A start strobe presents a mode word (a three-bit length code, an ordering select and a single-location-write select), a start column and a read/write flag. The next cycle the block begins to present one column address per clock, with a valid flag and a last-beat flag. Fixed-length bursts stay inside an aligned block of columns whose size is the burst length. Full-page bursts run around the whole row until a terminate input stops them.

A memory controller places this block beside its command sequencer. The controller issues the column command on each valid beat and uses the last-beat flag to schedule what comes next. A new accepted strobe replaces any burst in progress. A strobe that carries a length code with no defined meaning is refused and flagged for one cycle.

Top module: `burst_col_gen`

## Requirements
- R1: The length code `mode_len_i` decodes 000 to 1 beat, 001 to 2, 010 to 4 and 011 to 8. After an accepted strobe, `valid_o` is high for exactly that many cycles, starting the cycle after the strobe. `last_o` is high only on the final beat, and the first beat's column equals `start_col_i`.
- R2: With `mode_ilv_i`=0 (sequential), beat i carries the block base plus ((start offset + i) mod L).
- R3: With `mode_ilv_i`=1 (interleaved), beat i carries the block base plus (start offset XOR i). For example, length 8 from 5 gives 5,4,7,6,1,0,3,2.
- R4: On every beat of a fixed burst of length L, the column bits above log2(L) equal those of the start column.
- R5: Code 111 with `mode_ilv_i`=0 is a full-page burst. It steps sequentially over all 2^COL_W columns from the start, wrapping from the top column to 0, never raises `last_o`, and continues until terminated.
- R6: At length 1, `mode_ilv_i` has no effect on the single column produced.
- R7: When `mode_wsingle_i`=1, a strobe with `is_write_i`=1 gives one beat, while reads keep the programmed length. When `mode_wsingle_i`=0, writes use the programmed length.
- R8: `term_i` high at a clock edge with no accepted strobe ends the burst, so `valid_o` is low from the next cycle.
- R9: An accepted strobe during a burst replaces it, and the next cycle shows beat 0 of the new burst.
- R10: Codes 100, 101, 110, and 111 with `mode_ilv_i`=1, are rejected. `err_o` is high for exactly the cycle after the strobe, no addresses come from it, and a burst in progress continues unchanged.
- R11: During and straight after reset, `valid_o`, `last_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for a new burst |
| mode_len_i | input | 3 | Burst length code |
| mode_ilv_i | input | 1 | 0 sequential, 1 interleaved |
| mode_wsingle_i | input | 1 | 1 forces writes to a single location |
| is_write_i | input | 1 | 1 for a write burst, 0 for a read |
| start_col_i | input | COL_W | Starting column |
| term_i | input | 1 | Terminate the burst in progress |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Beat valid |
| last_o | output | 1 | Final beat of a fixed burst |
| err_o | output | 1 | Reserved-code strobe was refused |

## Verification
The vector table runs each length under both orderings, with start columns at the bottom, middle and top of their blocks and high in the row. This separates addition from XOR ordering, and in-block wrap from carry into the block bits. The read/write and single-write combinations separate the write shortening from the length decode. A full-page run crosses the top column, which tells the row wrap apart from a stop at the page end. Directed cases place termination, restart and reserved strobes in the middle of a burst, which shows whether each one stops, replaces or leaves alone the beats in flight.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [2:0] {
    BL_ONE  = 3'b000,
    BL_TWO  = 3'b001,
    BL_FOUR = 3'b010,
    BL_EIGHT = 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;

  // Column of beat `beat` given start, block span log2 `k` and ordering.
  function automatic logic [15:0] map_col(input logic [15:0] start,
                                          input logic [15:0] beat,
                                          input int unsigned k,
                                          input logic ilv,
                                          input int unsigned width);
    logic [15:0] sum;
    logic [15:0] col;
    sum = start + beat;
    col = '0;
    for (int unsigned i = 0; i < 16; i++) begin
      if (i < width) begin
        if (i < k) col[i] = ilv ? (start[i] ^ beat[i]) : sum[i];
        else       col[i] = start[i];
      end
    end
    return col;
  endfunction
endpackage

// File: rtl/bcg_mode_dec.sv
module bcg_mode_dec
  import bcg_pkg::*;
#(
  parameter int COL_W = 9,
  localparam int KW = $clog2(COL_W + 1)
) (
  input  logic [2:0]    len_code,
  input  logic          ilv,
  input  logic          wsingle,
  input  logic          is_write,
  output logic          ok,
  output logic          full,
  output logic [KW-1:0] span_log2
);
  always_comb begin
    ok = 1'b1;
    full = 1'b0;
    span_log2 = '0;
    case (bl_code_e'(len_code))
      BL_ONE:   span_log2 = KW'(0);
      BL_TWO:   span_log2 = KW'(1);
      BL_FOUR:  span_log2 = KW'(2);
      BL_EIGHT: span_log2 = KW'(3);
      BL_PAGE: begin
        if (ilv) ok = 1'b0;
        else begin
          full = 1'b1;
          span_log2 = KW'(COL_W);
        end
      end
      default: ok = 1'b0;
    endcase
    if (wsingle && is_write) begin
      full = 1'b0;
      span_log2 = '0;
    end
  end
endmodule

// File: rtl/bcg_burst_ctl.sv
module bcg_burst_ctl #(
  parameter int COL_W = 9,
  localparam int KW = $clog2(COL_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             reject,
  input  logic             full_in,
  input  logic [KW-1:0]    span_in,
  input  logic             ilv_in,
  input  logic [COL_W-1:0] start_in,
  input  logic             term_i,
  output logic             active,
  output logic             is_last,
  output logic             is_full,
  output logic             err,
  output logic [COL_W-1:0] beat,
  output logic [KW-1:0]    span,
  output logic             ilv,
  output logic [COL_W-1:0] start_col
);
  logic [COL_W-1:0] last_idx;
  logic stop_w;

  assign last_idx = ~({COL_W{1'b1}} << span);
  assign is_last  = active && !is_full && (beat == last_idx);
  assign stop_w   = active && (term_i || is_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      is_full   <= 1'b0;
      err       <= 1'b0;
      beat      <= '0;
      span      <= '0;
      ilv       <= 1'b0;
      start_col <= '0;
    end else begin
      err <= reject;
      if (accept) begin
        active    <= 1'b1;
        beat      <= '0;
        is_full   <= full_in;
        span      <= span_in;
        ilv       <= ilv_in;
        start_col <= start_in;
      end else if (stop_w) begin
        active <= 1'b0;
      end else if (active) begin
        beat <= beat + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
  import bcg_pkg::*;
#(
  parameter int COL_W = 9,
  localparam int KW = $clog2(COL_W + 1)
) (
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] beat,
  input  logic [KW-1:0]    span,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [15:0] wide;
  assign wide = map_col(16'(start_col), 16'(beat), int'(span), ilv, COL_W);
  assign col  = wide[COL_W-1:0];
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       mode_len_i,
  input  logic             mode_ilv_i,
  input  logic             mode_wsingle_i,
  input  logic             is_write_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  localparam int KW = $clog2(COL_W + 1);

  logic          ok_w, full_dec_w;
  logic [KW-1:0] span_dec_w;
  logic          accept_w, reject_w;
  logic          active_w, last_w, full_w, err_w, ilv_w;
  logic [COL_W-1:0] beat_w, start_w;
  logic [KW-1:0] span_w;

  bcg_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_code(mode_len_i), .ilv(mode_ilv_i), .wsingle(mode_wsingle_i),
    .is_write(is_write_i), .ok(ok_w), .full(full_dec_w), .span_log2(span_dec_w)
  );

  assign accept_w = start_i && ok_w;
  assign reject_w = start_i && !ok_w;

  bcg_burst_ctl #(.COL_W(COL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .reject(reject_w),
    .full_in(full_dec_w), .span_in(span_dec_w), .ilv_in(mode_ilv_i),
    .start_in(start_col_i), .term_i(term_i), .active(active_w),
    .is_last(last_w), .is_full(full_w), .err(err_w), .beat(beat_w),
    .span(span_w), .ilv(ilv_w), .start_col(start_w)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .start_col(start_w), .beat(beat_w), .span(span_w), .ilv(ilv_w), .col(col_o)
  );

  assign valid_o = active_w;
  assign last_o  = last_w;
  assign err_o   = err_w;
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             term_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             err_o,
  input logic             accept_w,
  input logic             reject_w,
  input logic             full_w
);
  a_r1_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> valid_o);
  a_r1_first_is_start: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> col_o == $past(start_col_i));
  a_r1_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && last_o && !accept_w) |=> !valid_o);
  a_r4_block_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !full_w && $past(valid_o) && !$past(accept_w))
      |-> col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]));
  a_r5_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    full_w |-> !last_o);
  a_r8_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (term_i && !accept_w) |=> !valid_o);
  a_r10_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    reject_w |=> err_o);
  a_r10_flag_single: assert property (@(posedge clk) disable iff (!rst_n)
    !reject_w |=> !err_o);
  a_r11_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .term_i(term_i), .start_col_i(start_col_i),
  .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o),
  .accept_w(accept_w), .reject_w(reject_w), .full_w(full_w)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  localparam int COL_W = 9;
  localparam int NV = 13;
  // fields: [18:16] code, [15] ilv, [14] wsingle, [13] write, [12:4] start, [3:0] beats
  localparam logic [18:0] VEC [NV] = '{
    {3'b000, 1'b0, 1'b0, 1'b0, 9'd5,   4'd1},
    {3'b000, 1'b1, 1'b0, 1'b0, 9'd6,   4'd1},
    {3'b001, 1'b0, 1'b0, 1'b0, 9'd3,   4'd2},
    {3'b001, 1'b1, 1'b0, 1'b0, 9'd2,   4'd2},
    {3'b010, 1'b1, 1'b0, 1'b0, 9'd1,   4'd4},
    {3'b010, 1'b0, 1'b0, 1'b0, 9'd6,   4'd4},
    {3'b011, 1'b1, 1'b0, 1'b0, 9'd5,   4'd8},
    {3'b011, 1'b0, 1'b0, 1'b0, 9'd3,   4'd8},
    {3'b011, 1'b0, 1'b0, 1'b0, 9'h1AB, 4'd8},
    {3'b011, 1'b1, 1'b0, 1'b1, 9'h0F2, 4'd8},
    {3'b011, 1'b0, 1'b1, 1'b1, 9'd4,   4'd1},
    {3'b010, 1'b0, 1'b1, 1'b0, 9'd9,   4'd4},
    {3'b011, 1'b1, 1'b1, 1'b1, 9'h1FF, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] mode_len_i = '0;
  logic mode_ilv_i = 1'b0, mode_wsingle_i = 1'b0, is_write_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic term_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic valid_o, last_o, err_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_len_i(mode_len_i),
    .mode_ilv_i(mode_ilv_i), .mode_wsingle_i(mode_wsingle_i),
    .is_write_i(is_write_i), .start_col_i(start_col_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  function automatic int ref_col(int start, int len, bit ilv, int i);
    int off, base;
    off  = start % len;
    base = start - off;
    return ilv ? base + (off ^ i) : base + ((off + i) % len);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(logic [2:0] code, bit ilv, bit ws, bit wr, int start);
    mode_len_i = code; mode_ilv_i = ilv; mode_wsingle_i = ws;
    is_write_i = wr; start_col_i = COL_W'(start); start_i = 1'b1;
  endtask

  // Called at a negedge with a strobe driven; ends at the negedge of beat 0.
  task automatic release_strobe();
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check(valid_o == 0, "R11 valid in reset", int'(valid_o), 0);
    check(last_o == 0, "R11 last in reset", int'(last_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(err_o == 0 && valid_o == 0, "R11 idle after reset", int'({err_o, valid_o}), 0);

    // Table walk: R1 R2 R3 R4 R6 R7
    for (int v = 0; v < NV; v++) begin
      int len, st, mism, lastbad;
      bit ilv;
      len = int'(VEC[v][3:0]);
      st  = int'(VEC[v][12:4]);
      ilv = VEC[v][15];
      mism = 0; lastbad = 0;
      strobe(VEC[v][18:16], VEC[v][15], VEC[v][14], VEC[v][13], st);
      release_strobe();
      for (int i = 0; i < len; i++) begin
        if (i > 0) @(negedge clk);
        if (!valid_o || int'(col_o) != ref_col(st, len, ilv, i)) begin
          if (mism == 0)
            check(1'b0, "R2/R3/R4/R6 order", int'(col_o), ref_col(st, len, ilv, i));
          mism++;
        end
        if (last_o != (i == len - 1)) lastbad++;
      end
      if (mism == 0) check(1'b1, "R2 R3 R4 R6 order", 0, 0);
      check(lastbad == 0, "R1 last flag", lastbad, 0);
      @(negedge clk);
      check(!valid_o, "R1 R7 beat count", int'(valid_o), 0);
    end

    // R5 full page from near the top, wrapping past column 511
    begin
      int mism;
      mism = 0;
      strobe(3'b111, 1'b0, 1'b0, 1'b0, 9'h1FC);
      release_strobe();
      for (int i = 0; i < 520; i++) begin
        if (i > 0) @(negedge clk);
        if (!valid_o || last_o || int'(col_o) != ((508 + i) % 512)) mism++;
      end
      check(mism == 0, "R5 page order", mism, 0);
      term_i = 1'b1;
      @(negedge clk);
      term_i = 1'b0;
      check(!valid_o, "R5 R8 page terminated", int'(valid_o), 0);
    end

    // R8 terminate a fixed burst at beat 1
    strobe(3'b011, 1'b0, 1'b0, 1'b0, 0);
    release_strobe();
    @(negedge clk);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    check(!valid_o, "R8 terminate", int'(valid_o), 0);

    // R9 restart mid burst
    strobe(3'b011, 1'b0, 1'b0, 1'b0, 16);
    release_strobe();
    @(negedge clk);
    @(negedge clk);
    strobe(3'b001, 1'b0, 1'b0, 1'b0, 5);
    release_strobe();
    check(valid_o && col_o == 9'd5, "R9 restart beat0", int'(col_o), 5);
    @(negedge clk);
    check(valid_o && last_o && col_o == 9'd4, "R9 restart beat1", int'(col_o), 4);
    @(negedge clk);
    check(!valid_o, "R9 replaced burst gone", int'(valid_o), 0);

    // R10 reserved code while idle
    strobe(3'b101, 1'b0, 1'b0, 1'b0, 7);
    release_strobe();
    check(err_o && !valid_o, "R10 reject idle", int'({err_o, valid_o}), 2);
    @(negedge clk);
    check(!err_o && !valid_o, "R10 flag one cycle", int'({err_o, valid_o}), 0);

    // R10 interleaved page code during a burst: burst continues
    strobe(3'b011, 1'b0, 1'b0, 1'b0, 0);
    release_strobe();
    @(negedge clk);
    @(negedge clk);
    strobe(3'b111, 1'b1, 1'b0, 1'b0, 100);
    release_strobe();
    check(err_o && valid_o && col_o == 9'd3, "R10 burst unchanged", int'(col_o), 3);
    @(negedge clk);
    check(!err_o && col_o == 9'd4, "R10 burst continues", int'(col_o), 4);

    done = 1'b1;
    finish_run();
  end
endmodule